// File: doc/BRIEF.md
# I2C Target with Byte-Level Clock Stretching

This block is a 7-bit-address I2C target (slave) for a host-side controller. It watches the open-drain SCL and SDA lines through synchronizers, finds START and STOP conditions, and shifts in an address frame. When the frame carries its own address it answers with ACK. Then it either accepts bytes from the bus controller or sends bytes to it. Both lines are modelled as open-drain: each has an input and an output-enable, and an enable of 1 pulls the line low.

The host side sees a one-byte receive buffer with a full flag, a one-byte transmit register, an interrupt flag, an overflow flag and a clock-release bit. After a read-address frame, and after every byte the controller acknowledges during a read, the target holds SCL low until the host sets the release bit. While receiving, the same hold after each byte is optional and is enabled by `stretch_en`. If that hold is off and the host has not emptied the buffer when the next byte completes, the overflow rule keeps the unread byte.

Top module: `i2c_stretch_slave`

## Requirements
- R1: Address bits 7..1 of the first byte after a START, sent MSB first, are compared with `own_addr`, and bit 0 is the R/W bit. On a match the target pulls SDA low for the 9th clock. On a mismatch it never pulls SDA low, and it ignores the bus until the next START.
- R2: In write mode, each byte received with the buffer empty is stored in `rx_data`. The target sets `buf_full` and `irq` and acknowledges the byte in the 9th clock.
- R3: A `host_rd` pulse clears `buf_full`. An `irq_clr` pulse clears both `irq` and `ovf`.
- R4: After a matched address with R/W = 1, the target holds SCL low from the falling edge of the 9th clock. It also raises `irq` and clears the release bit `rel`.
- R5: A `rel_set` pulse ends a hold. In read mode the byte last written through `tx_wr`/`tx_data` is then sent MSB first over the next 8 clocks.
- R6: After a sent byte, an ACK from the controller (SDA low in the 9th clock) starts a new hold and raises `irq`. A NACK releases both lines, and no further data is driven until a STOP or a START.
- R7: With `stretch_en` = 1, SCL is held low after the ACK of every received byte until `rel_set` is pulsed.
- R8: With `stretch_en` = 0, SCL is never held during write mode.
- R9: If a received byte completes while `buf_full` is 1, the target sets `ovf`, leaves `rx_data` unchanged and answers the byte with NACK.
- R10: A START is an SDA fall while SCL is high, and it restarts address reception from any state, including a repeated START. A STOP is an SDA rise while SCL is high, and after it both line enables are 0.
- R11: The target changes its SDA enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Target address |
| stretch_en | input | 1 | Hold SCL after each received byte |
| tx_data | input | 8 | Byte to send in read mode |
| tx_wr | input | 1 | Load `tx_data` into the transmit register |
| host_rd | input | 1 | Host has read `rx_data` |
| rel_set | input | 1 | Set the clock-release bit |
| irq_clr | input | 1 | Clear `irq` and `ovf` |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| irq | output | 1 | Byte-level event flag |
| ovf | output | 1 | A byte was refused because the buffer was full |
| rel | output | 1 | Clock-release bit |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. The target therefore reacts to an SCL edge within about four system clocks, and a bus model with eight-clock half periods can see every hold, ACK and data bit well inside one SCL phase. This makes the hold-versus-no-hold cases of R7 and R8 easy to tell apart with one fixed wait. The same holds for the overflow NACK and the NACK-ended read sequence.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_RX, S_ACK_RX,
    S_HOLD_RX, S_HOLD_TX, S_TX, S_ACK_TX, S_WAIT
  } slv_st_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [ADDR_W-1:0] own);
    return frame[BYTE_W-1:1] == own;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b1;
      else if (i == 0) chain[i] <= d;
      else chain[i] <= chain[(i == 0) ? 0 : i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_ev  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              stretch_en,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              host_rd,
  input  logic              rel_set,
  input  logic              irq_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              irq,
  output logic              ovf,
  output logic              rel
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  slv_st_t st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr, txsr, tx_buf, rx_buf;
  logic full_q, irq_q, ovf_q, rel_q, rw_q, ack_q, mack_q;
  logic byte_done, buf_busy;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));
  i2c_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  assign byte_done = scl_fall && (cnt == LAST_BIT);
  assign buf_busy  = full_q && !host_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  sr <= '0;  txsr <= '0;
      tx_buf <= '0;  rx_buf <= '0;
      full_q <= 1'b0; irq_q <= 1'b0; ovf_q <= 1'b0; rel_q <= 1'b0;
      rw_q <= 1'b0;  ack_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      if (tx_wr)   tx_buf <= tx_data;
      if (host_rd) full_q <= 1'b0;
      if (irq_clr) begin irq_q <= 1'b0; ovf_q <= 1'b0; end
      if (rel_set) rel_q <= 1'b1;

      if (stop_ev) begin
        st <= S_IDLE;
      end else if (start_ev) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else begin
        unique case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sr  <= {sr[BYTE_W-2:0], sda_s};
              cnt <= cnt + CNT_W'(1);
            end else if (byte_done) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (addr_hit(sr, own_addr)) begin
                  rw_q <= sr[0];
                  st   <= S_ACK_A;
                end else begin
                  st <= S_WAIT;
                end
              end else begin
                irq_q <= 1'b1;
                st    <= S_ACK_RX;
                if (buf_busy) begin
                  ovf_q <= 1'b1;
                  ack_q <= 1'b0;
                end else begin
                  rx_buf <= sr;
                  full_q <= 1'b1;
                  ack_q  <= 1'b1;
                end
              end
            end
          end
          S_ACK_A: if (scl_fall) begin
            if (rw_q) begin
              st <= S_HOLD_TX; irq_q <= 1'b1; rel_q <= 1'b0;
            end else begin
              st <= S_RX;
            end
          end
          S_ACK_RX: if (scl_fall) begin
            if (!ack_q) st <= S_WAIT;
            else if (stretch_en) begin
              st <= S_HOLD_RX; rel_q <= 1'b0;
            end else st <= S_RX;
          end
          S_HOLD_RX: if (rel_q) st <= S_RX;
          S_HOLD_TX: if (rel_q) begin
            txsr <= tx_buf;
            st   <= S_TX;
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + CNT_W'(1);
            else if (byte_done) begin
              cnt <= '0;
              st  <= S_ACK_TX;
            end else if (scl_fall) txsr <= {txsr[BYTE_W-2:0], 1'b0};
          end
          S_ACK_TX: begin
            if (scl_rise) mack_q <= ~sda_s;
            else if (scl_fall) begin
              if (mack_q) begin
                st <= S_HOLD_TX; irq_q <= 1'b1; rel_q <= 1'b0;
              end else st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe   = (st == S_HOLD_RX) || (st == S_HOLD_TX);
  assign sda_oe   = (st == S_ACK_A) || ((st == S_ACK_RX) && ack_q) ||
                    ((st == S_TX) && !txsr[BYTE_W-1]);
  assign rx_data  = rx_buf;
  assign buf_full = full_q;
  assign irq      = irq_q;
  assign ovf      = ovf_q;
  assign rel      = rel_q;

  // R4
  rel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !rel);
  // R9
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> rx_data == $past(rx_data));
  // R3
  full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(host_rd));
  // R11
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scl_fall));
endmodule

// File: tb/i2c_stretch_slave_tb.sv
module i2c_stretch_slave_tb;
  localparam int HALF = 8;
  localparam logic [6:0] OWN = 7'h5A;
  localparam logic [7:0] VEC [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic stretch_en = 1'b0, tx_wr = 1'b0, host_rd = 1'b0;
  logic rel_set = 1'b0, irq_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_oe, sda_oe, buf_full, irq, ovf, rel;
  logic [7:0] rx_data;
  int total = 0, failed = 0, r11_bad = 0;

  wire scl_line = !(m_scl_low || scl_oe);
  wire sda_line = !(m_sda_low || sda_oe);

  always #4 clk = ~clk;

  i2c_stretch_slave #(.SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .stretch_en(stretch_en), .tx_data(tx_data), .tx_wr(tx_wr),
    .host_rd(host_rd), .rel_set(rel_set), .irq_clr(irq_clr),
    .rx_data(rx_data), .buf_full(buf_full), .irq(irq), .ovf(ovf), .rel(rel));

  function automatic logic [7:0] frame(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic m_bit_w(input logic b);
    m_sda_low = !b; wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF); m_scl_low = 1'b1; wait_cyc(4);
  endtask

  task automatic m_bit_r(output logic b);
    m_sda_low = 1'b0; wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF); b = sda_line; m_scl_low = 1'b1; wait_cyc(4);
  endtask

  task automatic m_write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
    m_bit_r(b);
    ack = !b;
  endtask

  task automatic m_read_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_bit_r(b); d[i] = b; end
    m_bit_w(!give_ack);
  endtask

  task automatic m_start;
    m_sda_low = 1'b0; wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF); m_sda_low = 1'b1; wait_cyc(HALF);
    m_scl_low = 1'b1; wait_cyc(4);
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1; wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF); m_sda_low = 1'b0; wait_cyc(HALF);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  logic prev_sda_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_sda_oe) && scl_line && prev_scl) r11_bad++;
    prev_sda_oe <= sda_oe;
    prev_scl    <= scl_line;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
  end

  initial begin
    logic ack;
    logic [7:0] got;
    wait_cyc(5); rst_n = 1'b1; wait_cyc(2);
    chk("R10 reset scl_oe", scl_oe, 0);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R3 reset buf_full", buf_full, 0);
    chk("R2 reset irq", irq, 0);
    chk("R9 reset ovf", ovf, 0);

    // R1: foreign address is not acknowledged, following byte ignored
    m_start();
    m_write_byte(frame(7'h23, 1'b0), ack);
    chk("R1 mismatch nack", ack, 0);
    m_write_byte(8'h66, ack);
    chk("R1 ignored byte nack", ack, 0);
    chk("R1 ignored byte buf_full", buf_full, 0);
    // R10: repeated START restarts address reception
    m_start();
    m_write_byte(frame(OWN, 1'b0), ack);
    chk("R10 repeated start ack", ack, 1);
    m_stop();
    chk("R10 stop scl_oe", scl_oe, 0);
    chk("R10 stop sda_oe", sda_oe, 0);

    // R2/R8: table-driven write sequence, no hold
    m_start();
    m_write_byte(frame(OWN, 1'b0), ack);
    chk("R1 match ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      m_write_byte(VEC[i], ack);
      chk("R2 data ack", ack, 1);
      chk("R2 rx_data", rx_data, VEC[i]);
      chk("R2 buf_full", buf_full, 1);
      chk("R2 irq", irq, 1);
      wait_cyc(20);
      chk("R8 no hold", scl_oe, 0);
      pulse(host_rd);
      chk("R3 read clears full", buf_full, 0);
      pulse(irq_clr);
      chk("R3 irq cleared", irq, 0);
    end
    m_stop();

    // R9: overflow when buffer not read
    m_start();
    m_write_byte(frame(OWN, 1'b0), ack);
    m_write_byte(8'h11, ack);
    chk("R2 first byte ack", ack, 1);
    m_write_byte(8'h22, ack);
    chk("R9 overflow nack", ack, 0);
    chk("R9 ovf set", ovf, 1);
    chk("R9 old data kept", rx_data, 8'h11);
    chk("R9 still full", buf_full, 1);
    m_stop();
    pulse(irq_clr);
    chk("R3 ovf cleared", ovf, 0);
    chk("R3 irq cleared after ovf", irq, 0);
    pulse(host_rd);

    // R7: hold after received bytes
    stretch_en = 1'b1;
    m_start();
    m_write_byte(frame(OWN, 1'b0), ack);
    m_write_byte(8'h7E, ack);
    wait_cyc(20);
    chk("R7 hold after rx byte", scl_oe, 1);
    chk("R7 rel cleared", rel, 0);
    pulse(host_rd);
    pulse(irq_clr);
    pulse(rel_set);
    wait_cyc(4);
    chk("R7 hold released", scl_oe, 0);
    m_write_byte(8'h81, ack);
    chk("R7 second byte rx", rx_data, 8'h81);
    wait_cyc(20);
    chk("R7 hold again", scl_oe, 1);
    pulse(host_rd);
    pulse(irq_clr);
    pulse(rel_set);
    wait_cyc(4);
    m_stop();
    stretch_en = 1'b0;

    // R4/R5/R6: read sequence
    m_start();
    m_write_byte(frame(OWN, 1'b1), ack);
    chk("R1 read addr ack", ack, 1);
    wait_cyc(20);
    chk("R4 hold after read addr", scl_oe, 1);
    chk("R4 irq", irq, 1);
    chk("R4 rel cleared", rel, 0);
    tx_data = 8'hC3; pulse(tx_wr);
    pulse(irq_clr);
    pulse(rel_set);
    wait_cyc(4);
    m_read_byte(1'b1, got);
    chk("R5 tx byte", got, 8'hC3);
    wait_cyc(20);
    chk("R6 hold after ack", scl_oe, 1);
    chk("R6 irq after ack", irq, 1);
    tx_data = 8'h5E; pulse(tx_wr);
    pulse(irq_clr);
    pulse(rel_set);
    wait_cyc(4);
    m_read_byte(1'b0, got);
    chk("R5 second tx byte", got, 8'h5E);
    wait_cyc(20);
    chk("R6 nack releases scl", scl_oe, 0);
    chk("R6 nack releases sda", sda_oe, 0);
    m_read_byte(1'b0, got);
    chk("R6 nothing driven after nack", got, 8'hFF);
    m_stop();

    chk("R11 sda changes while scl high", r11_bad, 0);
    summary();
  end
endmodule